// File: doc/BRIEF.md
# Falling-Edge Restarted Processor Watchdog

This block watches a strobe line driven by a processor and raises a timeout when the processor stops showing signs of life. Only a high-to-low transition on the strobe counts as life. Each such edge restarts the count. If no edge arrives before the selected period has passed, the block emits a one-clock timeout pulse. A separate reset generator turns that pulse into a stretched system reset.

The block runs on the system clock. Time is measured with a 1 kHz tick enable, so one tick is one millisecond. A two-bit select picks one of three periods. The shortest period is `BASE_TICKS` ticks, with a default of 150 (150 ms). The other two periods are four times and eight times that length (600 ms and 1200 ms by default). Every nominal period sits inside the accepted windows of 62.5–250 ms, 250–1000 ms and 500–2000 ms.

The strobe is asynchronous. It passes through a two-flop synchroniser before edge detection, so a low level lasting one clock period (20 ns at 50 MHz) is seen as activity. A hold input, driven while the downstream reset is active, keeps the block cleared.

Top module: `wdg_edge_watchdog`

## Requirements
- R1: While `rst_n` is low, `timeout_pulse` is 0. After `rst_n` is released, the count starts from zero: the first timeout follows exactly one full period of ticks.
- R2: With `period_sel` = 2'b00, a timeout occurs on the `BASE_TICKS`-th tick after the last restart. `timeout_pulse` rises in the clock after the clock edge that samples that tick.
- R3: With `period_sel` = 2'b01, the timeout occurs on the 4×`BASE_TICKS`-th tick after the last restart.
- R4: With `period_sel` = 2'b10, the timeout occurs on the 8×`BASE_TICKS`-th tick after the last restart. Code 2'b11 behaves exactly like 2'b10.
- R5: A high-to-low transition of `strobe` restarts the count from zero. A low level lasting a single clock period is enough.
- R6: A low-to-high transition of `strobe` does not restart the count.
- R7: `timeout_pulse` is exactly one clock wide. The count restarts from zero on it, so with no strobe activity timeouts repeat once every period.
- R8: While `hold` is 1, the count stays at zero and no timeout is raised, whatever ticks arrive. After `hold` returns to 0, a full period is needed before a timeout.
- R9: The count advances only on clocks where `tick_1k` is 1. Any number of clocks without a tick raises no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1k | input | 1 | One-clock enable pulse at 1 kHz (one per millisecond) |
| hold | input | 1 | Keeps the count cleared and suppresses timeouts while 1 |
| period_sel | input | 2 | Period select: 00 short, 01 4× short, 10 or 11 8× short |
| strobe | input | 1 | Asynchronous activity strobe from the processor |
| timeout_pulse | output | 1 | One-clock pulse when the period expires without a falling edge |

## Verification
The assertions assume the following about the inputs:
- `tick_1k` is a clean, synchronous one-clock enable.
- `strobe` may change at any time, but its falling edges are far enough apart to pass through the synchroniser one by one.
- `period_sel` is held steady while a period is being timed.

The stimulus drives every input on the falling clock edge and spaces ticks four clocks apart. After each strobe transition it waits three idle clocks before the next tick, so an edge never coincides with a tick. It changes the select only just before a restarting falling edge, which keeps the expected timeout tick unambiguous.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    SEL_SHORT    = 2'b00,
    SEL_MID      = 2'b01,
    SEL_LONG     = 2'b10,
    SEL_LONG_ALT = 2'b11
  } wdg_sel_e;

  localparam int unsigned MID_RATIO  = 4;
  localparam int unsigned LONG_RATIO = 8;

  function automatic int unsigned cnt_width(input int unsigned base_ticks);
    return $clog2(base_ticks * LONG_RATIO);
  endfunction

endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;

  // each stage samples the one before it; stage 0 samples the pin
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sync_d[g] = strobe_i;
    end else begin : g_rest
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_comb begin
    prev_d = sync_q[LAST];
  end

  // idle level of the strobe is high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/wdg_period_dec.sv
module wdg_period_dec
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 150,
  parameter int unsigned CW         = cnt_width(BASE_TICKS)
) (
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] term_o
);
  localparam logic [CW-1:0] TERM_SHORT = CW'(BASE_TICKS - 1);
  localparam logic [CW-1:0] TERM_MID   = CW'(BASE_TICKS * MID_RATIO - 1);
  localparam logic [CW-1:0] TERM_LONG  = CW'(BASE_TICKS * LONG_RATIO - 1);

  wdg_sel_e sel;

  always_comb begin
    sel = wdg_sel_e'(sel_i);
    unique case (sel)
      SEL_SHORT:    term_o = TERM_SHORT;
      SEL_MID:      term_o = TERM_MID;
      SEL_LONG:     term_o = TERM_LONG;
      SEL_LONG_ALT: term_o = TERM_LONG;
      default:      term_o = TERM_LONG;
    endcase
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          hold_i,
  input  logic [CW-1:0] term_i,
  output logic [CW-1:0] count_o,
  output logic          timeout_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          to_q;
  logic          to_d;

  always_comb begin
    cnt_d = cnt_q;
    to_d  = 1'b0;
    if (hold_i || restart_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      // >= keeps a lowered select from letting the count run past its end
      if (cnt_q >= term_i) begin
        cnt_d = '0;
        to_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign count_o   = cnt_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/wdg_edge_watchdog.sv
module wdg_edge_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_TICKS  = 150,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1k,
  input  logic       hold,
  input  logic [1:0] period_sel,
  input  logic       strobe,
  output logic       timeout_pulse
);
  localparam int unsigned CW = cnt_width(BASE_TICKS);

  logic          rst_sync_n;
  logic          fall_evt;
  logic [CW-1:0] term_cnt;
  logic [CW-1:0] count_q;

  wdg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  wdg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .strobe_i (strobe),
    .fall_o   (fall_evt)
  );

  wdg_period_dec #(.BASE_TICKS(BASE_TICKS), .CW(CW)) u_dec (
    .sel_i  (period_sel),
    .term_o (term_cnt)
  );

  wdg_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick_1k),
    .restart_i (fall_evt),
    .hold_i    (hold),
    .term_i    (term_cnt),
    .count_o   (count_q),
    .timeout_o (timeout_pulse)
  );
endmodule

// File: rtl/wdg_edge_watchdog_chk.sv
module wdg_edge_watchdog_chk #(
  parameter int unsigned CW = 11
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          tick_1k,
  input logic          hold,
  input logic          fall_evt,
  input logic [CW-1:0] count_q,
  input logic          timeout_pulse
);
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    timeout_pulse |=> !timeout_pulse);

  p_pulse_clears_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    timeout_pulse |-> (count_q == '0));

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold |=> ((count_q == '0) && !timeout_pulse));

  p_fall_restart_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fall_evt |=> ((count_q == '0) && !timeout_pulse));

  p_no_tick_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick_1k |=> !timeout_pulse);

  p_no_tick_stable_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tick_1k && !fall_evt && !hold) |=> $stable(count_q));
endmodule

bind wdg_edge_watchdog wdg_edge_watchdog_chk #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .tick_1k       (tick_1k),
  .hold          (hold),
  .fall_evt      (fall_evt),
  .count_q       (count_q),
  .timeout_pulse (timeout_pulse)
);

// File: tb/wdg_edge_watchdog_tb.sv
module wdg_edge_watchdog_tb;
  localparam int BASE = 6;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1k;
  logic       hold;
  logic [1:0] period_sel;
  logic       strobe;
  logic       timeout_pulse;

  always #10 clk = ~clk;

  wdg_edge_watchdog #(.BASE_TICKS(BASE), .SYNC_STAGES(2)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_1k       (tick_1k),
    .hold          (hold),
    .period_sel    (period_sel),
    .strobe        (strobe),
    .timeout_pulse (timeout_pulse)
  );

  typedef struct {
    int    at;
    string req;
  } exp_t;

  exp_t  expq[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    since = 0;
  int    limit = BASE;
  string cur_req = "R1";
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every pulse must match the oldest expected timeout
  always @(negedge clk) begin
    if (rst_n === 1'b1 && timeout_pulse === 1'b1) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected timeout at cycle %0d (actual 1, expected 0)", cur_req, cyc);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (e.at != cyc) begin
          errors++;
          $display("FAIL %s: timeout at cycle %0d (expected %0d)", e.req, cyc, e.at);
        end
      end
    end
  end

  task automatic step(input logic t);
    @(negedge clk);
    tick_1k = t;
    if (t && !hold) begin
      since++;
      if (since >= limit) begin
        expq.push_back('{at: cyc + 1, req: cur_req});
        since = 0;
      end
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      repeat (TDIV - 1) step(1'b0);
    end
  endtask

  task automatic set_strobe(input logic v);
    @(negedge clk);
    tick_1k = 1'b0;
    if (strobe === 1'b1 && v == 1'b0) since = 0;
    strobe = v;
    repeat (3) step(1'b0);
  endtask

  // low for `width` clocks, then high again
  task automatic kick(input int width);
    @(negedge clk);
    tick_1k = 1'b0;
    strobe  = 1'b0;
    since   = 0;
    repeat (width - 1) step(1'b0);
    @(negedge clk);
    strobe = 1'b1;
    repeat (3) step(1'b0);
  endtask

  task automatic set_hold(input logic v);
    @(negedge clk);
    tick_1k = 1'b0;
    hold    = v;
    since   = 0;
    step(1'b0);
  endtask

  task automatic set_sel(input logic [1:0] s);
    @(negedge clk);
    tick_1k    = 1'b0;
    period_sel = s;
    case (s)
      2'b00:   limit = BASE;
      2'b01:   limit = 4 * BASE;
      default: limit = 8 * BASE;
    endcase
  endtask

  task automatic drain(input string req);
    repeat (3) step(1'b0);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected timeouts missing (actual queue %0d, expected 0)", req, expq.size(), expq.size());
      expq.delete();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    tick_1k = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    since = 0;
    repeat (3) step(1'b0);
  endtask

  initial begin
    rst_n      = 1'b0;
    tick_1k    = 1'b0;
    hold       = 1'b0;
    period_sel = 2'b00;
    strobe     = 1'b1;
    // R1: output quiet in reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (timeout_pulse !== 1'b0) begin
        errors++;
        $display("FAIL R1: timeout_pulse in reset (actual %b, expected 0)", timeout_pulse);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0);

    cur_req = "R2"; ticks(BASE);      drain("R2");
    cur_req = "R7"; ticks(3 * BASE);  drain("R7");

    cur_req = "R5";
    kick(2); ticks(BASE - 1);
    kick(1); ticks(BASE - 1);
    drain("R5");
    ticks(1); drain("R5");

    cur_req = "R6";
    set_strobe(1'b0); ticks(BASE - 2);
    set_strobe(1'b1); ticks(2);
    drain("R6");

    cur_req = "R8";
    ticks(BASE - 1);
    set_hold(1'b1); ticks(3 * BASE); drain("R8");
    set_hold(1'b0); ticks(BASE);     drain("R8");

    cur_req = "R9";
    ticks(BASE - 1);
    repeat (200) step(1'b0);
    drain("R9");
    ticks(1); drain("R9");

    cur_req = "R3"; set_sel(2'b01); kick(1); ticks(4 * BASE + 3); drain("R3");
    cur_req = "R4"; set_sel(2'b10); kick(1); ticks(8 * BASE);     drain("R4");
    set_sel(2'b11); kick(1); ticks(8 * BASE - 1); drain("R4"); ticks(1); drain("R4");

    cur_req = "R1";
    ticks(BASE);
    do_reset();
    ticks(8 * BASE);
    drain("R1");

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
  end
endmodule